// File: doc/BRIEF.md
# Dedicated IO Bank Freeze/Thaw Sequencer

This block drives the protection controls of a dedicated IO bank while the core behind it is reconfigured. A freeze puts the pads into a safe parked state in three timed steps. These steps cover the slew limiter, weak pull-up, tristate and bus-hold. They also drop the configuration-done indication and assert the regulator, termination and DLL resets. A thaw undoes this in six steps. The thaw mixes short fixed clock-cycle gaps with two long waits. Those two waits are counted in pulses of an internal-oscillator tick enable.

Software or a power sequencer issues one-cycle freeze or thaw request pulses. The block reports `busy` while a sequence runs and `frozen` once the bank is parked. After reset the bank is frozen, so a thaw is the first useful request.

Top module: `iobank_frz_seq`

## Requirements
- R1: While `rst_n` is low and after its release, `frozen`=1 and `busy`=0. The controls are `slew_lim_n`=0, `weak_pu_n`=0, `tristate_n`=0, `bushold_n`=0, `cfg_done`=0, `vreg_rst`=1, `term_rst`=1, `dll_rst`=1 and `cal_bias_en`=0. An assertion of `rst_n` in the middle of a sequence returns the bank to this state.
- R2: A `freeze_req` sampled high while thawed and idle applies the first freeze step on that same clock edge. That step drives `slew_lim_n`, `weak_pu_n` and `tristate_n` to 0 and raises `busy`.
- R3: Exactly GAP_CYC clock cycles after the first freeze step, the second step applies: `bushold_n`=0, `cfg_done`=0, `vreg_rst`=1 and `term_rst`=1.
- R4: Exactly GAP_CYC cycles after the second step, the third step applies: `dll_rst`=1, `cal_bias_en`=0, `frozen`=1 and `busy`=0.
- R5: A `thaw_req` sampled high while frozen and idle clears `dll_rst` on that edge and raises `busy`. Exactly GAP_CYC cycles later, `cal_bias_en` rises.
- R6: After `cal_bias_en` rises, the block counts `osc_tick` pulses sampled on later edges. On the edge that samples pulse number LONG_TICKS, it sets `bushold_n`=1 and `cfg_done`=1 and clears `term_rst`. Ticks that arrive while idle are not counted.
- R7: On the edge that samples the SHORT_TICKS-th later `osc_tick` pulse, `weak_pu_n` and `tristate_n` both go to 1.
- R8: GAP_CYC cycles after R7, `vreg_rst` clears. GAP_CYC cycles after that, `slew_lim_n` goes to 1, `frozen` clears and `busy` drops.
- R9: A freeze or thaw request sampled while `busy`=1 is dropped. It changes neither the outputs nor the timing of the running sequence.
- R10: A `freeze_req` while frozen, a `thaw_req` while thawed, or `osc_tick` pulses while idle leave every output unchanged.
- R11: `dll_rst` and `cal_bias_en` are never high at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| freeze_req | input | 1 | One-cycle freeze request |
| thaw_req | input | 1 | One-cycle thaw request |
| osc_tick | input | 1 | One-cycle enable per internal-oscillator cycle |
| slew_lim_n | output | 1 | Slew limiter enable, active low |
| weak_pu_n | output | 1 | Weak pull-up enable, active low |
| tristate_n | output | 1 | Pad tristate, active low |
| bushold_n | output | 1 | Bus-hold enable, active low |
| cfg_done | output | 1 | Configuration done indication |
| vreg_rst | output | 1 | Regulator reset |
| term_rst | output | 1 | On-chip termination reset |
| dll_rst | output | 1 | DLL reset |
| cal_bias_en | output | 1 | Calibration start / bias enable |
| frozen | output | 1 | Bank is parked |
| busy | output | 1 | A sequence is running |

## Verification
The hardest case to reach is a request that lands inside one of the long tick-counted thaw waits. A wrong design could restart or shorten the count there, and the error would only show a thousand ticks later. The bench spaces the tick pulses two cycles apart so that each wait can be stopped one pulse before its end. It inserts stray freeze and thaw pulses during both a clock-gap wait and a tick wait. Then it confirms that the next step still lands on the exact expected pulse. A reset asserted in the middle of a thaw, and ticks issued while idle before a thaw, cover the remaining cases where the counter could carry stale state.

// File: rtl/iobank_frz_pkg.sv
package iobank_frz_pkg;

  typedef struct packed {
    logic slew_lim_n;
    logic weak_pu_n;
    logic tristate_n;
    logic bushold_n;
    logic cfg_done;
    logic vreg_rst;
    logic term_rst;
    logic dll_rst;
    logic cal_bias_en;
  } ctrl_t;

  typedef enum logic [3:0] {
    STP_NONE = 4'd0,
    STP_F1   = 4'd1,
    STP_F2   = 4'd2,
    STP_F3   = 4'd3,
    STP_T1   = 4'd4,
    STP_T2   = 4'd5,
    STP_T3   = 4'd6,
    STP_T4   = 4'd7,
    STP_T5   = 4'd8,
    STP_T6   = 4'd9
  } step_e;

  // parked state of every control line
  function automatic ctrl_t ctrl_parked();
    ctrl_t c;
    c.slew_lim_n  = 1'b0;
    c.weak_pu_n   = 1'b0;
    c.tristate_n  = 1'b0;
    c.bushold_n   = 1'b0;
    c.cfg_done    = 1'b0;
    c.vreg_rst    = 1'b1;
    c.term_rst    = 1'b1;
    c.dll_rst     = 1'b1;
    c.cal_bias_en = 1'b0;
    return c;
  endfunction

  // effect of one step on the control lines
  function automatic ctrl_t ctrl_apply(ctrl_t c, step_e s);
    ctrl_t n;
    n = c;
    case (s)
      STP_F1: begin
        n.slew_lim_n = 1'b0;
        n.weak_pu_n  = 1'b0;
        n.tristate_n = 1'b0;
      end
      STP_F2: begin
        n.bushold_n = 1'b0;
        n.cfg_done  = 1'b0;
        n.vreg_rst  = 1'b1;
        n.term_rst  = 1'b1;
      end
      STP_F3: begin
        n.cal_bias_en = 1'b0;
        n.dll_rst     = 1'b1;
      end
      STP_T1: n.dll_rst = 1'b0;
      STP_T2: n.cal_bias_en = 1'b1;
      STP_T3: begin
        n.bushold_n = 1'b1;
        n.cfg_done  = 1'b1;
        n.term_rst  = 1'b0;
      end
      STP_T4: begin
        n.weak_pu_n  = 1'b1;
        n.tristate_n = 1'b1;
      end
      STP_T5: n.vreg_rst = 1'b0;
      STP_T6: n.slew_lim_n = 1'b1;
      default: n = c;
    endcase
    return n;
  endfunction

  // wait length that follows a step (0: none, sequence ends)
  function automatic int unsigned wait_after(step_e s, int unsigned gap,
                                             int unsigned lng, int unsigned sht);
    case (s)
      STP_F1, STP_F2, STP_T1, STP_T4, STP_T5: return gap;
      STP_T2: return lng;
      STP_T3: return sht;
      default: return 0;
    endcase
  endfunction

  // whether the wait after a step counts oscillator ticks
  function automatic logic wait_on_tick(step_e s);
    return (s == STP_T2) || (s == STP_T3);
  endfunction

  function automatic int unsigned at_least_one(int unsigned v);
    return (v == 0) ? 1 : v;
  endfunction

endpackage

// File: rtl/iobank_frz_req_gate.sv
module iobank_frz_req_gate (
  input  logic freeze_req,
  input  logic thaw_req,
  input  logic busy,
  input  logic frozen,
  output logic start_freeze,
  output logic start_thaw,
  output logic drop_req
);
  always_comb begin
    start_freeze = freeze_req && !busy && !frozen;
    start_thaw   = thaw_req && !busy && frozen;
    drop_req     = (freeze_req || thaw_req) && !start_freeze && !start_thaw;
  end
endmodule

// File: rtl/iobank_frz_timer.sv
module iobank_frz_timer #(
  parameter int CNT_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             load_tick,
  input  logic             osc_tick,
  output logic             fire
);
  logic [CNT_W-1:0] cnt_q;
  logic             tick_mode_q;
  logic             step_en;

  assign step_en = tick_mode_q ? osc_tick : 1'b1;
  assign fire    = (cnt_q == CNT_W'(1)) && step_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q       <= '0;
      tick_mode_q <= 1'b0;
    end else if (load) begin
      cnt_q       <= load_val;
      tick_mode_q <= load_tick;
    end else if (step_en && (cnt_q != '0)) begin
      cnt_q <= cnt_q - CNT_W'(1);
    end
  end
endmodule

// File: rtl/iobank_frz_fsm.sv
module iobank_frz_fsm
  import iobank_frz_pkg::*;
#(
  parameter int GAP_CYC     = 5,
  parameter int LONG_TICKS  = 1000,
  parameter int SHORT_TICKS = 33,
  parameter int CNT_W       = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_freeze,
  input  logic             start_thaw,
  input  logic             fire,
  output step_e            step_now,
  output logic             load,
  output logic [CNT_W-1:0] load_val,
  output logic             load_tick,
  output logic             busy
);
  typedef enum logic [2:0] {
    S_IDLE, S_F_G1, S_F_G2, S_T_G1, S_T_LONG, S_T_SHORT, S_T_G4, S_T_G5
  } st_e;

  localparam int unsigned GAP_L   = at_least_one(GAP_CYC);
  localparam int unsigned LONG_L  = at_least_one(LONG_TICKS);
  localparam int unsigned SHORT_L = at_least_one(SHORT_TICKS);

  st_e st_q, st_d;

  always_comb begin
    step_now = STP_NONE;
    st_d     = st_q;
    case (st_q)
      S_IDLE: begin
        if (start_freeze) begin
          step_now = STP_F1; st_d = S_F_G1;
        end else if (start_thaw) begin
          step_now = STP_T1; st_d = S_T_G1;
        end
      end
      S_F_G1:    if (fire) begin step_now = STP_F2; st_d = S_F_G2;    end
      S_F_G2:    if (fire) begin step_now = STP_F3; st_d = S_IDLE;    end
      S_T_G1:    if (fire) begin step_now = STP_T2; st_d = S_T_LONG;  end
      S_T_LONG:  if (fire) begin step_now = STP_T3; st_d = S_T_SHORT; end
      S_T_SHORT: if (fire) begin step_now = STP_T4; st_d = S_T_G4;    end
      S_T_G4:    if (fire) begin step_now = STP_T5; st_d = S_T_G5;    end
      S_T_G5:    if (fire) begin step_now = STP_T6; st_d = S_IDLE;    end
      default:   st_d = S_IDLE;
    endcase
  end

  always_comb begin
    load_val  = CNT_W'(wait_after(step_now, GAP_L, LONG_L, SHORT_L));
    load_tick = wait_on_tick(step_now);
    load      = (step_now != STP_NONE);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= S_IDLE;
    else        st_q <= st_d;
  end

  assign busy = (st_q != S_IDLE);
endmodule

// File: rtl/iobank_frz_ctrl_reg.sv
module iobank_frz_ctrl_reg
  import iobank_frz_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  step_e step_now,
  output ctrl_t ctrl,
  output logic  frozen
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl   <= ctrl_parked();
      frozen <= 1'b1;
    end else begin
      ctrl <= ctrl_apply(ctrl, step_now);
      if (step_now == STP_F3)      frozen <= 1'b1;
      else if (step_now == STP_T6) frozen <= 1'b0;
    end
  end
endmodule

// File: rtl/iobank_frz_seq.sv
module iobank_frz_seq
  import iobank_frz_pkg::*;
#(
  parameter int GAP_CYC     = 5,
  parameter int LONG_TICKS  = 1000,
  parameter int SHORT_TICKS = 33
) (
  input  logic clk,
  input  logic rst_n,
  input  logic freeze_req,
  input  logic thaw_req,
  input  logic osc_tick,
  output logic slew_lim_n,
  output logic weak_pu_n,
  output logic tristate_n,
  output logic bushold_n,
  output logic cfg_done,
  output logic vreg_rst,
  output logic term_rst,
  output logic dll_rst,
  output logic cal_bias_en,
  output logic frozen,
  output logic busy
);
  localparam int MAX_A = (GAP_CYC > LONG_TICKS) ? GAP_CYC : LONG_TICKS;
  localparam int MAX_W = (MAX_A > SHORT_TICKS) ? MAX_A : SHORT_TICKS;
  localparam int CNT_W = $clog2(MAX_W + 2);

  logic             start_freeze, start_thaw, drop_req;
  logic             timer_fire, load, load_tick;
  logic [CNT_W-1:0] load_val;
  step_e            step_now;
  ctrl_t            ctrl;

  iobank_frz_req_gate u_gate (
    .freeze_req  (freeze_req),
    .thaw_req    (thaw_req),
    .busy        (busy),
    .frozen      (frozen),
    .start_freeze(start_freeze),
    .start_thaw  (start_thaw),
    .drop_req    (drop_req)
  );

  iobank_frz_fsm #(
    .GAP_CYC(GAP_CYC), .LONG_TICKS(LONG_TICKS),
    .SHORT_TICKS(SHORT_TICKS), .CNT_W(CNT_W)
  ) u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_freeze(start_freeze),
    .start_thaw  (start_thaw),
    .fire        (timer_fire),
    .step_now    (step_now),
    .load        (load),
    .load_val    (load_val),
    .load_tick   (load_tick),
    .busy        (busy)
  );

  iobank_frz_timer #(.CNT_W(CNT_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (load),
    .load_val (load_val),
    .load_tick(load_tick),
    .osc_tick (osc_tick),
    .fire     (timer_fire)
  );

  iobank_frz_ctrl_reg u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .step_now(step_now),
    .ctrl    (ctrl),
    .frozen  (frozen)
  );

  assign slew_lim_n  = ctrl.slew_lim_n;
  assign weak_pu_n   = ctrl.weak_pu_n;
  assign tristate_n  = ctrl.tristate_n;
  assign bushold_n   = ctrl.bushold_n;
  assign cfg_done    = ctrl.cfg_done;
  assign vreg_rst    = ctrl.vreg_rst;
  assign term_rst    = ctrl.term_rst;
  assign dll_rst     = ctrl.dll_rst;
  assign cal_bias_en = ctrl.cal_bias_en;
endmodule

// File: rtl/iobank_frz_seq_chk.sv
module iobank_frz_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic freeze_req,
  input logic thaw_req,
  input logic osc_tick,
  input logic slew_lim_n,
  input logic weak_pu_n,
  input logic tristate_n,
  input logic bushold_n,
  input logic cfg_done,
  input logic vreg_rst,
  input logic term_rst,
  input logic dll_rst,
  input logic cal_bias_en,
  input logic frozen,
  input logic busy,
  input logic drop_req,
  input logic timer_fire
);
  logic [8:0] ctl;
  assign ctl = {slew_lim_n, weak_pu_n, tristate_n, bushold_n, cfg_done,
                vreg_rst, term_rst, dll_rst, cal_bias_en};

  // R2
  start_from_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> !$past(busy) && ($past(freeze_req) || $past(thaw_req)));

  // R2
  freeze_first_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(busy) && !frozen) |-> !slew_lim_n && !weak_pu_n && !tristate_n && bushold_n);

  // R4
  parked_on_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(frozen) |-> dll_rst && !cal_bias_en && !bushold_n && vreg_rst && term_rst && !busy);

  // R6
  release_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bushold_n) |-> $past(osc_tick) && cal_bias_en && !dll_rst && !term_rst);

  // R7
  pads_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(weak_pu_n) |-> $past(osc_tick) && tristate_n && bushold_n);

  // R8
  vreg_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(vreg_rst) |-> weak_pu_n && tristate_n && !slew_lim_n);

  // R8
  thaw_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(frozen) |-> slew_lim_n && !vreg_rst && !busy);

  // R9
  dropped_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (drop_req && !timer_fire) |=> $stable(ctl) && $stable(busy) && $stable(frozen));

  // R10
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !freeze_req && !thaw_req) |=> $stable(ctl) && $stable(frozen));

  // R11
  dll_cal_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(dll_rst && cal_bias_en));
endmodule

bind iobank_frz_seq iobank_frz_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .freeze_req(freeze_req), .thaw_req(thaw_req),
  .osc_tick(osc_tick), .slew_lim_n(slew_lim_n), .weak_pu_n(weak_pu_n),
  .tristate_n(tristate_n), .bushold_n(bushold_n), .cfg_done(cfg_done),
  .vreg_rst(vreg_rst), .term_rst(term_rst), .dll_rst(dll_rst),
  .cal_bias_en(cal_bias_en), .frozen(frozen), .busy(busy),
  .drop_req(drop_req), .timer_fire(timer_fire)
);

// File: tb/iobank_frz_seq_tb.sv
module iobank_frz_seq_tb;
  localparam int G  = 5;
  localparam int LT = 1000;
  localparam int ST = 33;

  localparam logic [1:0] OP_CYC = 2'd0, OP_FRZ = 2'd1, OP_THW = 2'd2, OP_TCK = 2'd3;

  // {slew_lim_n,weak_pu_n,tristate_n,bushold_n,cfg_done,vreg_rst,term_rst,dll_rst,cal_bias_en,frozen,busy}
  localparam logic [10:0] E_FROZ = 11'b00000111010;
  localparam logic [10:0] E_THAW = 11'b11111000100;
  localparam logic [10:0] E_A    = 11'b00000110011;
  localparam logic [10:0] E_B    = 11'b00000110111;
  localparam logic [10:0] E_C    = 11'b00011100111;
  localparam logic [10:0] E_D    = 11'b01111100111;
  localparam logic [10:0] E_E    = 11'b01111000111;
  localparam logic [10:0] E_F    = 11'b00011000101;
  localparam logic [10:0] E_H    = 11'b00000110101;

  // {req[3:0], op[1:0], n[15:0], exp[10:0]}
  localparam int NV = 20;
  localparam logic [32:0] VEC [NV] = '{
    {4'd1,  OP_CYC, 16'd0,      E_FROZ}, // R1 reset state
    {4'd5,  OP_THW, 16'd0,      E_A},    // R5 dll release
    {4'd5,  OP_CYC, 16'(G-1),   E_A},    // R5
    {4'd5,  OP_CYC, 16'd1,      E_B},    // R5 cal enable
    {4'd6,  OP_TCK, 16'(LT-1),  E_B},    // R6
    {4'd6,  OP_TCK, 16'd1,      E_C},    // R6
    {4'd7,  OP_TCK, 16'(ST-1),  E_C},    // R7
    {4'd7,  OP_TCK, 16'd1,      E_D},    // R7
    {4'd8,  OP_CYC, 16'(G-1),   E_D},    // R8
    {4'd8,  OP_CYC, 16'd1,      E_E},    // R8
    {4'd8,  OP_CYC, 16'(G-1),   E_E},    // R8
    {4'd8,  OP_CYC, 16'd1,      E_THAW}, // R8
    {4'd10, OP_TCK, 16'd3,      E_THAW}, // R10 ticks while idle
    {4'd2,  OP_FRZ, 16'd0,      E_F},    // R2
    {4'd2,  OP_CYC, 16'(G-1),   E_F},    // R2
    {4'd3,  OP_CYC, 16'd1,      E_H},    // R3
    {4'd3,  OP_CYC, 16'(G-1),   E_H},    // R3
    {4'd4,  OP_CYC, 16'd1,      E_FROZ}, // R4
    {4'd10, OP_FRZ, 16'd0,      E_FROZ}, // R10 freeze while frozen
    {4'd10, OP_TCK, 16'd4,      E_FROZ}  // R10
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic freeze_req = 1'b0, thaw_req = 1'b0, osc_tick = 1'b0;
  logic slew_lim_n, weak_pu_n, tristate_n, bushold_n, cfg_done;
  logic vreg_rst, term_rst, dll_rst, cal_bias_en, frozen, busy;
  int   n_tests = 0, n_fail = 0;
  bit   done = 1'b0;
  bit   excl_seen = 1'b0;
  int   cyc = 0;

  always #4 clk = ~clk;

  iobank_frz_seq #(.GAP_CYC(G), .LONG_TICKS(LT), .SHORT_TICKS(ST)) u_dut (
    .clk(clk), .rst_n(rst_n), .freeze_req(freeze_req), .thaw_req(thaw_req),
    .osc_tick(osc_tick), .slew_lim_n(slew_lim_n), .weak_pu_n(weak_pu_n),
    .tristate_n(tristate_n), .bushold_n(bushold_n), .cfg_done(cfg_done),
    .vreg_rst(vreg_rst), .term_rst(term_rst), .dll_rst(dll_rst),
    .cal_bias_en(cal_bias_en), .frozen(frozen), .busy(busy)
  );

  wire [10:0] obs = {slew_lim_n, weak_pu_n, tristate_n, bushold_n, cfg_done,
                     vreg_rst, term_rst, dll_rst, cal_bias_en, frozen, busy};

  // R11 monitor
  always @(negedge clk) if (rst_n && dll_rst && cal_bias_en) excl_seen = 1'b1;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000 && !done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: run hung, actual cycle %0d expected below 150000", cyc);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  task automatic check(input logic [10:0] exp, input int req);
    n_tests++;
    if (obs !== exp) begin
      n_fail++;
      $display("FAIL R%0d: actual %b expected %b", req, obs, exp);
    end
  endtask

  task automatic cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic pulse_frz();
    freeze_req = 1'b1; @(negedge clk); freeze_req = 1'b0;
  endtask

  task automatic pulse_thw();
    thaw_req = 1'b1; @(negedge clk); thaw_req = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      osc_tick = 1'b1; @(negedge clk); osc_tick = 1'b0;
    end
  endtask

  initial begin
    cycles(3);
    rst_n = 1'b1;
    @(negedge clk);

    for (int v = 0; v < NV; v++) begin
      case (VEC[v][28:27])
        OP_FRZ: pulse_frz();
        OP_THW: pulse_thw();
        OP_TCK: ticks(int'(VEC[v][26:11]));
        default: cycles(int'(VEC[v][26:11]));
      endcase
      check(VEC[v][10:0], int'(VEC[v][32:29]));
    end

    // R9: stray requests during a gap wait and a tick wait
    pulse_thw();
    pulse_frz();
    pulse_thw();
    cycles(G-3);
    check(E_A, 9);
    cycles(1);
    check(E_B, 9);
    ticks(LT);
    check(E_C, 9);
    pulse_frz();
    pulse_thw();
    ticks(ST-1);
    check(E_C, 9);
    ticks(1);
    check(E_D, 9);
    cycles(G);
    check(E_E, 8);
    cycles(G);
    check(E_THAW, 8);

    // R10: thaw while already thawed
    pulse_thw();
    check(E_THAW, 10);
    cycles(2);
    check(E_THAW, 10);

    // R9: thaw during a running freeze
    pulse_frz();
    pulse_thw();
    cycles(G-2);
    check(E_F, 9);
    cycles(1);
    check(E_H, 9);
    cycles(G);
    check(E_FROZ, 4);

    // R1: reset in the middle of a thaw
    pulse_thw();
    cycles(G);
    ticks(10);
    rst_n = 1'b0;
    @(negedge clk);
    check(E_FROZ, 1);
    rst_n = 1'b1;
    cycles(2);
    check(E_FROZ, 1);
    // R6: counter restarts cleanly after reset
    pulse_thw();
    check(E_A, 6);
    cycles(G);
    ticks(LT-1);
    check(E_B, 6);
    ticks(1);
    check(E_C, 6);

    // R11
    n_tests++;
    if (excl_seen) begin
      n_fail++;
      $display("FAIL R11: actual overlap 1 expected 0");
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule